// File: doc/BRIEF.md
# Non-Maskable Interrupt Request Arbiter

This block merges two non-maskable interrupt sources into one request to the CPU. The first source is an external pin. The pin is synchronised, and its edges are detected under a programmable edge mode. The second source is a watchdog overflow pulse, which only counts while the watchdog is in its interrupt mode. Each source has its own pending latch. The arbiter picks one pending request and presents it as a valid flag with a one-bit source code. The CPU takes the request with an acknowledge strobe.

An internal in-service bit records that non-maskable handling is under way. While that bit is set, a new pin request always waits for the return-from-interrupt strobe. A new watchdog request waits only while the CPU's NMI-in-progress flag is high. When that flag is low, the watchdog request is presented at once and pre-empts the running handler. The CPU's maskable-interrupt disable state has no input here and no effect.

Top module: `nmiReqArbiter`

## Requirements
- R1: After reset `reqValid` is 0. The pin edge mode field `edgeSel` encodes 00 = no detection, 01 = rising, 10 = falling, 11 = both. With 00, no pin activity ever raises a request.
- R2: With `edgeSel`=01, a 0-to-1 change on `pinIn` raises `reqValid` with `reqSrc`=0 three clock edges later. A 1-to-0 change raises nothing.
- R3: With `edgeSel`=10, only a 1-to-0 change on `pinIn` raises a pin request, with the same three-edge latency.
- R4: With `edgeSel`=11, both directions of change on `pinIn` raise a pin request.
- R5: A `wdtOvf` pulse sets the watchdog pending latch, visible one clock edge later, only when `wdtMode`=01. Modes 00, 10 and 11 ignore the pulse.
- R6: `reqSrc` is 1 for the watchdog and 0 for the pin. When both are pending and no service is active, the watchdog is presented.
- R7: `cpuAck` while `reqValid` is 1 clears the pending latch of the presented source and sets the in-service state. `cpuAck` while `reqValid` is 0 changes nothing.
- R8: While service is active, a pending pin request is not presented, whatever `nmiInProg` says. It is presented after `retStrobe`, which ends the service.
- R9: While service is active and `nmiInProg` is 1, a pending watchdog request is held. It is presented after `retStrobe`.
- R10: While service is active and `nmiInProg` is 0, a new watchdog request is presented one edge after its pulse, pre-empting the current service.
- R11: A new event for a source arriving in the same cycle as the acknowledge of that source leaves its pending latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | Asynchronous external interrupt pin |
| wdtOvf | input | 1 | Watchdog overflow pulse, one cycle |
| wdtMode | input | 2 | Watchdog mode; 01 routes overflow to this block |
| edgeSel | input | 2 | Pin edge mode: 00 none, 01 rise, 10 fall, 11 both |
| cpuAck | input | 1 | CPU takes the presented request |
| retStrobe | input | 1 | Return from the non-maskable handler |
| nmiInProg | input | 1 | CPU flag: non-maskable handling in progress |
| reqValid | output | 1 | A non-maskable request is presented |
| reqSrc | output | 1 | Source of the request: 1 watchdog, 0 pin |

## Verification
A pin change appears on `reqValid` three rising edges after it is driven: two synchroniser stages, then the pending latch. The directed checks therefore sample at the falling edge after the second edge, expecting nothing, and after the third, expecting the request. Watchdog pulses, acknowledges and return strobes all act through a single register, so their effect is checked at the falling edge that follows the next rising edge. The random phase compares the outputs at every falling edge with a cycle model that the bench builds from the same latencies.

// File: rtl/nmiArbPkg.sv
package nmiArbPkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeMode_e;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_WDT = 1'b1
  } nmiSrc_e;

  localparam logic [1:0] WDT_MODE_NMI = 2'b01;

  typedef struct packed {
    logic clrPin;
    logic clrWdt;
    logic setSvc;
    logic clrSvc;
  } ctlStrobes_t;

endpackage

// File: rtl/nmiDatapath.sv
module nmiDatapath
  import nmiArbPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              wdtOvf,
  input  logic [MODE_W-1:0] wdtMode,
  input  logic [1:0]        edgeSel,
  input  ctlStrobes_t       ctl,
  output logic              pinPend,
  output logic              wdtPend,
  output logic              inService
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevLvl;
  logic curLvl;
  logic riseEv;
  logic fallEv;
  logic pinEvent;
  logic wdtEvent;
  edgeMode_e edgeMode;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], pinIn};
      end
    end
  endgenerate

  assign curLvl = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= curLvl;
  end

  assign riseEv   = curLvl & ~prevLvl;
  assign fallEv   = ~curLvl & prevLvl;
  assign edgeMode = edgeMode_e'(edgeSel);

  always_comb begin
    unique case (edgeMode)
      EDGE_RISE: pinEvent = riseEv;
      EDGE_FALL: pinEvent = fallEv;
      EDGE_BOTH: pinEvent = riseEv | fallEv;
      default:   pinEvent = 1'b0;
    endcase
  end

  assign wdtEvent = wdtOvf && (wdtMode == MODE_W'(WDT_MODE_NMI));

  // A fresh event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPend   <= 1'b0;
      wdtPend   <= 1'b0;
      inService <= 1'b0;
    end else begin
      pinPend   <= pinEvent | (pinPend & ~ctl.clrPin);
      wdtPend   <= wdtEvent | (wdtPend & ~ctl.clrWdt);
      inService <= ctl.setSvc | (inService & ~ctl.clrSvc);
    end
  end

endmodule

// File: rtl/nmiControl.sv
module nmiControl
  import nmiArbPkg::*;
(
  input  logic        pinPend,
  input  logic        wdtPend,
  input  logic        inService,
  input  logic        nmiInProg,
  input  logic        cpuAck,
  input  logic        retStrobe,
  output logic        reqValid,
  output logic        reqSrc,
  output ctlStrobes_t ctl
);

  logic presentWdt;
  logic presentPin;
  logic takeIt;

  // Watchdog may pre-empt service only while the in-progress flag is clear.
  assign presentWdt = wdtPend & (~inService | ~nmiInProg);
  // Pin waits for any active service to end.
  assign presentPin = pinPend & ~inService & ~presentWdt;

  assign reqValid = presentWdt | presentPin;
  assign reqSrc   = presentWdt ? SRC_WDT : SRC_PIN;
  assign takeIt   = cpuAck & reqValid;

  always_comb begin
    ctl        = '0;
    ctl.clrWdt = takeIt & presentWdt;
    ctl.clrPin = takeIt & presentPin;
    ctl.setSvc = takeIt;
    ctl.clrSvc = retStrobe;
  end

endmodule

// File: rtl/nmiReqArbiter.sv
module nmiReqArbiter
  import nmiArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       wdtOvf,
  input  logic [1:0] wdtMode,
  input  logic [1:0] edgeSel,
  input  logic       cpuAck,
  input  logic       retStrobe,
  input  logic       nmiInProg,
  output logic       reqValid,
  output logic       reqSrc
);

  ctlStrobes_t ctl;
  logic pinPend;
  logic wdtPend;
  logic inService;

  nmiDatapath #(.SYNC_STAGES(SYNC_STAGES), .MODE_W(2)) uData (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wdtOvf(wdtOvf),
    .wdtMode(wdtMode), .edgeSel(edgeSel), .ctl(ctl),
    .pinPend(pinPend), .wdtPend(wdtPend), .inService(inService)
  );

  nmiControl uCtl (
    .pinPend(pinPend), .wdtPend(wdtPend), .inService(inService),
    .nmiInProg(nmiInProg), .cpuAck(cpuAck), .retStrobe(retStrobe),
    .reqValid(reqValid), .reqSrc(reqSrc), .ctl(ctl)
  );

endmodule

// File: rtl/nmiReqArbiterChecker.sv
module nmiReqArbiterChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wdtOvf,
  input logic [1:0] wdtMode,
  input logic       cpuAck,
  input logic       retStrobe,
  input logic       nmiInProg,
  input logic       reqValid,
  input logic       reqSrc,
  input logic       wdtPend,
  input logic       inService
);

  assert_wdt_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtPend) |-> $past(wdtOvf && wdtMode == 2'b01));

  assert_wdt_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wdtPend && !inService) |-> (reqValid && reqSrc));

  assert_ack_service_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && reqValid) |=> inService);

  assert_pin_waits_R8: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !(reqValid && !reqSrc));

  assert_ret_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !(cpuAck && reqValid)) |=> !inService);

  assert_wdt_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inService && nmiInProg) |-> !reqValid);

  assert_wdt_preempt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !nmiInProg && wdtPend) |-> (reqValid && reqSrc));

endmodule

bind nmiReqArbiter nmiReqArbiterChecker uChk (
  .clk(clk), .rstN(rstN), .wdtOvf(wdtOvf), .wdtMode(wdtMode),
  .cpuAck(cpuAck), .retStrobe(retStrobe), .nmiInProg(nmiInProg),
  .reqValid(reqValid), .reqSrc(reqSrc), .wdtPend(wdtPend),
  .inService(inService)
);

// File: tb/sim_nmiReqArbiter.sv
`timescale 1ns/1ps
module sim_nmiReqArbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0, wdtOvf = 1'b0, cpuAck = 1'b0, retStrobe = 1'b0, nmiInProg = 1'b0;
  logic [1:0] wdtMode = 2'b00, edgeSel = 2'b00;
  logic reqValid, reqSrc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nmiReqArbiter u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wdtOvf(wdtOvf), .wdtMode(wdtMode),
    .edgeSel(edgeSel), .cpuAck(cpuAck), .retStrobe(retStrobe),
    .nmiInProg(nmiInProg), .reqValid(reqValid), .reqSrc(reqSrc)
  );

  // Cycle model built from the requirements.
  logic mS1, mS2, mPrev, mPin, mWdt, mSvc;

  function automatic logic expValid(logic p, logic w, logic s, logic np);
    return (w && (!s || !np)) || (p && !s);
  endfunction

  function automatic logic expSrc(logic w, logic s, logic np);
    return w && (!s || !np);
  endfunction

  function automatic logic edgeFound(logic [1:0] sel, logic cur, logic prv);
    case (sel)
      2'b01:   return cur && !prv;
      2'b10:   return !cur && prv;
      2'b11:   return cur != prv;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mPrev <= 0; mPin <= 0; mWdt <= 0; mSvc <= 0;
    end else begin
      logic v, s, take;
      v = expValid(mPin, mWdt, mSvc, nmiInProg);
      s = expSrc(mWdt, mSvc, nmiInProg);
      take = cpuAck && v;
      mS1 <= pinIn; mS2 <= mS1; mPrev <= mS2;
      mPin <= edgeFound(edgeSel, mS2, mPrev) || (mPin && !(take && !s));
      mWdt <= (wdtOvf && wdtMode == 2'b01) || (mWdt && !(take && s));
      mSvc <= take || (mSvc && !retStrobe);
    end
  end

  task automatic chk(string req, logic expV, logic expS);
    checks++;
    if (reqValid !== expV || (expV && reqSrc !== expS)) begin
      errors++;
      $display("FAIL %s: reqValid/reqSrc actual %b/%b expected %b/%b",
               req, reqValid, reqSrc, expV, expS);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ackRet();
    cpuAck = 1; cyc(1); cpuAck = 0;
    retStrobe = 1; cyc(1); retStrobe = 0;
  endtask

  task automatic wdtPulse();
    wdtOvf = 1; cyc(1); wdtOvf = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    cyc(3); rstN = 1; cyc(1);
    chk("R1 reset", 0, 0);

    // R1: no detection mode ignores pin toggling
    for (int i = 0; i < 6; i++) begin pinIn = ~pinIn; cyc(1); end
    pinIn = 0; cyc(4);
    chk("R1 edge none", 0, 0);

    // R2 rising
    edgeSel = 2'b01; pinIn = 1; cyc(2);
    chk("R2 before latency", 0, 0);
    cyc(1);
    chk("R2 rising", 1, 0);
    cpuAck = 1; cyc(1); cpuAck = 0;
    chk("R7 ack clears pin", 0, 0);
    retStrobe = 1; cyc(1); retStrobe = 0;
    pinIn = 0; cyc(4);
    chk("R2 falling ignored", 0, 0);

    // R3 falling
    edgeSel = 2'b10; pinIn = 1; cyc(4);
    chk("R3 rising ignored", 0, 0);
    pinIn = 0; cyc(3);
    chk("R3 falling", 1, 0);
    ackRet();

    // R4 both
    edgeSel = 2'b11; pinIn = 1; cyc(3);
    chk("R4 rise", 1, 0);
    ackRet();
    pinIn = 0; cyc(3);
    chk("R4 fall", 1, 0);
    ackRet();

    // R5 watchdog mode gate
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        wdtMode = 2'(m); wdtPulse(); cyc(2);
        chk("R5 mode ignored", 0, 0);
      end
    end
    wdtMode = 2'b01; wdtPulse();
    chk("R5 mode 01", 1, 1);
    ackRet();

    // R6 priority, R8 pin waits, R7 ack with no request
    pinIn = 1; cyc(3);
    chk("R6 pin alone", 1, 0);
    wdtPulse();
    chk("R6 watchdog wins", 1, 1);
    cpuAck = 1; cyc(1); cpuAck = 0;
    chk("R8 pin held in service", 0, 0);
    cpuAck = 1; cyc(1); cpuAck = 0;
    retStrobe = 1; cyc(1); retStrobe = 0;
    chk("R7 idle ack no effect / R8 released", 1, 0);
    ackRet();

    // R9 watchdog held while in-progress flag set
    wdtPulse();
    cpuAck = 1; nmiInProg = 1; cyc(1); cpuAck = 0;
    wdtPulse();
    chk("R9 held", 0, 0);
    cyc(2);
    chk("R9 still held", 0, 0);
    retStrobe = 1; nmiInProg = 0; cyc(1); retStrobe = 0;
    chk("R9 after return", 1, 1);
    ackRet();

    // R10 pre-emption
    wdtPulse();
    cpuAck = 1; cyc(1); cpuAck = 0;
    chk("R10 service active", 0, 0);
    wdtPulse();
    chk("R10 preempt", 1, 1);
    ackRet();

    // R11 new event with acknowledge
    wdtPulse();
    cpuAck = 1; wdtOvf = 1; cyc(1); cpuAck = 0; wdtOvf = 0;
    chk("R11 latch kept", 1, 1);
    ackRet();
    cyc(1);
    chk("R11 cleared after ack", 0, 0);

    // Random phase against the cycle model (R2..R11)
    for (int i = 0; i < 4000; i++) begin
      chk("R6 R8 R9 R10 random", expValid(mPin, mWdt, mSvc, nmiInProg),
          expSrc(mWdt, mSvc, nmiInProg));
      if ($urandom_range(7) == 0) pinIn = ~pinIn;
      if ($urandom_range(63) == 0) edgeSel = 2'($urandom_range(3));
      wdtOvf    = ($urandom_range(15) == 0);
      wdtMode   = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'b01;
      cpuAck    = ($urandom_range(3) == 0);
      retStrobe = ($urandom_range(7) == 0);
      nmiInProg = $urandom_range(1) != 0;
      cyc(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule